// File: doc/BRIEF.md
# Paced Single-Channel Word DMA with Ping-Pong Halves

This block is one DMA channel. It moves 32-bit words between a peripheral port and a memory port. Software programs it through a small word-addressed register file, which holds control, status, two address pointers, two sequence words and a global word. On the peripheral side, each word can be paced by a request/acknowledge handshake. Both ports read combinationally, so a granted beat reads the source and writes the destination in the same cycle.

The channel has two modes. In one-shot mode it moves a single block of count+1 words and then stops. In continuous mode every block of count+1 words is one half of a double buffer. At the end of each half the channel raises the end-of-count status, flips a ping-pong flag and reloads the count. After the second half, the working pointers restart from the pointer registers. Software can rewrite those registers during a run, and the new values take effect at the next buffer start.

A pending transfer can be frozen by selecting request source 31. While frozen, the remaining count can be read back. Bus-width, burst and swap fields are stored and read back, but every beat moves one 32-bit word.

Top module: `dma_pingpong_chan`

## Requirements
- R1: After reset, all registers read zero, `irq` and `perAck` are low, and no port strobe (`memWe`, `memRe`, `perWe`) is active.
- R2: Register map by `regAddr`: 0 control, 1 status, 2 memory pointer, 3 memory sequence, 4 peripheral pointer, 5 peripheral sequence, 6 global. Writing control with bit 31 set while idle starts the channel. Status then shows busy in bit 31, and bits 15:2 show the remaining count, loaded from control bits 15:2.
- R3: A beat happens in a cycle when the channel is running and one of two conditions holds: control bit 21 (paced) is set and `perReq` is high, or bit 21 is clear. Paced beats pulse `perAck` in the same cycle. Each beat lowers the remaining count by one.
- R4: With control bit 28 clear, a beat drives `memWe` and copies `perRdata` to `memWdata`. With bit 28 set, it drives `memRe` and `perWe` and copies `memRdata` to `perWdata`.
- R5: Both pointers advance by 4 per beat. Wrap is set by sequence bits 18:16 (code c). On the memory side, c≠0 sets a window of 16<<c words. On the peripheral side, c≠0 sets a window of 1<<(c-1) words. At the end of a window the pointer returns to its start address.
- R6: With control bit 27 (once) set, the beat at count 0 ends the block: busy and control bit 31 read 0, and status bit 30 is set.
- R7: With bit 27 clear, the beat at count 0 sets status bit 30, toggles the ping-pong flag (status bit 28) and reloads the count. The pointers continue after the first half and restart at the end of the second half.
- R8: Pointer register writes made during a run do not move the active pointers until the next buffer start.
- R9: A request selector (control bits 20:16) of 31, or hold (control bit 29) set, blocks all beats. Busy and the count keep their values.
- R10: Writing control with bit 31 clear stops the channel. Busy reads 0 from the next cycle, and no further beats happen.
- R11: Writing status with bit 30 set clears the end-of-count status. Writing status with bit 30 clear leaves it unchanged.
- R12: `irq` is high exactly when all four of these are set: global bit 31, global bit 0 (channel mask), status bit 30 and control bit 30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word index |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| perReq | input | 1 | Peripheral word request |
| perAck | output | 1 | Peripheral acknowledge, one per paced beat |
| perAddr | output | 32 | Peripheral-side pointer |
| perWe | output | 1 | Peripheral write strobe |
| perWdata | output | 32 | Data to the peripheral |
| perRdata | input | 32 | Data from the peripheral |
| memAddr | output | 32 | Memory-side pointer |
| memWe | output | 1 | Memory write strobe |
| memRe | output | 1 | Memory read strobe |
| memWdata | output | 32 | Data to memory |
| memRdata | input | 32 | Data from memory |
| irq | output | 1 | Channel interrupt |

## Verification
Beat strobes, `perAck`, addresses and data mux outputs are combinational. They are due in the same cycle the request is driven, so the bench drives inputs on the falling edge and samples one nanosecond later. Count, busy, ping-pong and status-bit changes appear one clock after the beat or register write that causes them. The bench therefore reads status on the falling edge that follows that rising edge. Expected pointers are computed as base plus 4·(i mod window), and expected counts as count−i, over sweeps of direction, length, pacing and wrap codes.

// File: rtl/dma_pingpong_pkg.sv
package dma_pingpong_pkg;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = 14;
  localparam int WIN_W   = 12;
  localparam int SEL_W   = 5;
  localparam logic [SEL_W-1:0] SEL_BLOCKED = 5'd31;

  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_STAT   = 3'd1;
  localparam logic [2:0] A_MPTR   = 3'd2;
  localparam logic [2:0] A_MSEQ   = 3'd3;
  localparam logic [2:0] A_PPTR   = 3'd4;
  localparam logic [2:0] A_PSEQ   = 3'd5;
  localparam logic [2:0] A_GLOBAL = 3'd6;

  typedef struct packed {
    logic load;    // restart walkers from the pointer registers
    logic step;    // one word beat
    logic toPer;   // direction: memory to peripheral
  } walkCmd_t;
endpackage

// File: rtl/dma_ptr_walker.sv
module dma_ptr_walker
  import dma_pingpong_pkg::*;
#(
  parameter int PTR_W = DATA_W,
  parameter int IDX_W = WIN_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic             step,
  input  logic [PTR_W-1:0] base,
  input  logic [IDX_W-1:0] window,
  output logic [PTR_W-1:0] ptr
);
  logic [PTR_W-1:0] startQ;
  logic [IDX_W-1:0] idxQ;
  logic             atEdge;

  assign atEdge = (window != '0) && (idxQ == window - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr    <= '0;
      startQ <= '0;
      idxQ   <= '0;
    end else if (load) begin
      ptr    <= base;
      startQ <= base;
      idxQ   <= '0;
    end else if (step) begin
      if (atEdge) begin
        ptr  <= startQ;
        idxQ <= '0;
      end else begin
        ptr  <= ptr + PTR_W'(4);
        idxQ <= idxQ + 1'b1;
      end
    end
  end

  // R5: linear advance when no window is selected
  p_linear_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (step && !load && window == '0) |=> ptr == $past(ptr) + PTR_W'(4));
  // R5: the last word of a window sends the pointer back to its start
  p_wrap_return_r5: assert property (@(posedge clk) disable iff (!rstN)
    (step && !load && atEdge) |=> ptr == startQ);
  // R8: a load takes the base presented at that edge
  p_load_base_r8: assert property (@(posedge clk) disable iff (!rstN)
    load |=> ptr == $past(base));
endmodule

// File: rtl/dma_pingpong_ctrl.sv
module dma_pingpong_ctrl
  import dma_pingpong_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              perReq,
  output logic              perAck,
  output logic              irq,
  output walkCmd_t          cmd,
  output logic [DATA_W-1:0] memBase,
  output logic [DATA_W-1:0] perBase,
  output logic [2:0]        memWrapCode,
  output logic [2:0]        perWrapCode
);
  logic [30:0]       ctrlQ;
  logic              enableQ, busyQ, intStatQ, pingQ;
  logic [CNT_W-1:0]  remQ;
  logic [DATA_W-1:0] memPtrQ, memSeqQ, perPtrQ, perSeqQ;
  logic              globalEnQ, irqMaskQ;

  logic              ieEoc, holdBit, toPer, onceBit, paced;
  logic [SEL_W-1:0]  reqSel;
  logic [CNT_W-1:0]  wordCnt;
  logic              wrCtrl, wrStat, startNow, stopNow, beatGo, lastBeat;

  assign ieEoc   = ctrlQ[30];
  assign holdBit = ctrlQ[29];
  assign toPer   = ctrlQ[28];
  assign onceBit = ctrlQ[27];
  assign paced   = ctrlQ[21];
  assign reqSel  = ctrlQ[20:16];
  assign wordCnt = ctrlQ[15:2];

  assign wrCtrl   = regWe && regAddr == A_CTRL;
  assign wrStat   = regWe && regAddr == A_STAT;
  assign startNow = wrCtrl && regWdata[31] && !busyQ;
  assign stopNow  = wrCtrl && !regWdata[31];

  assign beatGo   = busyQ && enableQ && !holdBit && reqSel != SEL_BLOCKED &&
                    (perReq || !paced) && !stopNow;
  assign lastBeat = beatGo && remQ == '0;

  assign cmd.load  = startNow || (lastBeat && !onceBit && pingQ);
  assign cmd.step  = beatGo;
  assign cmd.toPer = toPer;

  assign perAck      = beatGo && paced;
  assign irq         = globalEnQ && irqMaskQ && intStatQ && ieEoc;
  assign memBase     = memPtrQ;
  assign perBase     = perPtrQ;
  assign memWrapCode = memSeqQ[18:16];
  assign perWrapCode = perSeqQ[18:16];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ     <= '0;
      memPtrQ   <= '0;
      memSeqQ   <= '0;
      perPtrQ   <= '0;
      perSeqQ   <= '0;
      globalEnQ <= 1'b0;
      irqMaskQ  <= 1'b0;
    end else if (regWe) begin
      unique case (regAddr)
        A_CTRL:   ctrlQ   <= regWdata[30:0];
        A_MPTR:   memPtrQ <= regWdata;
        A_MSEQ:   memSeqQ <= regWdata;
        A_PPTR:   perPtrQ <= regWdata;
        A_PSEQ:   perSeqQ <= regWdata;
        A_GLOBAL: begin
          globalEnQ <= regWdata[31];
          irqMaskQ  <= regWdata[0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= 1'b0;
      busyQ   <= 1'b0;
      pingQ   <= 1'b0;
      remQ    <= '0;
    end else if (stopNow) begin
      enableQ <= 1'b0;
      busyQ   <= 1'b0;
    end else if (startNow) begin
      enableQ <= 1'b1;
      busyQ   <= 1'b1;
      pingQ   <= 1'b0;
      remQ    <= regWdata[15:2];
    end else if (beatGo) begin
      if (remQ == '0) begin
        if (onceBit) begin
          enableQ <= 1'b0;
          busyQ   <= 1'b0;
        end else begin
          pingQ <= ~pingQ;
          remQ  <= wordCnt;
        end
      end else begin
        remQ <= remQ - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       intStatQ <= 1'b0;
    else if (lastBeat)               intStatQ <= 1'b1;
    else if (wrStat && regWdata[30]) intStatQ <= 1'b0;
  end

  always_comb begin
    unique case (regAddr)
      A_CTRL:   regRdata = {enableQ, ctrlQ};
      A_STAT:   regRdata = {busyQ, intStatQ, 1'b0, pingQ, 12'd0, remQ, 2'd0};
      A_MPTR:   regRdata = memPtrQ;
      A_MSEQ:   regRdata = memSeqQ;
      A_PPTR:   regRdata = perPtrQ;
      A_PSEQ:   regRdata = perSeqQ;
      A_GLOBAL: regRdata = {globalEnQ, 30'd0, irqMaskQ};
      default:  regRdata = '0;
    endcase
  end

  // R9: a blocked selector freezes busy and the remaining count
  p_freeze_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && reqSel == SEL_BLOCKED && !regWe) |=> busyQ && $stable(remQ));
  // R3: acknowledge only from a running channel
  p_ack_running_r3: assert property (@(posedge clk) disable iff (!rstN)
    perAck |-> (busyQ && enableQ && perReq));
  // R6: one-shot block end
  p_oneshot_end_r6: assert property (@(posedge clk) disable iff (!rstN)
    (lastBeat && onceBit) |=> (!busyQ && !enableQ && intStatQ));
  // R7: half end in continuous mode
  p_half_flip_r7: assert property (@(posedge clk) disable iff (!rstN)
    (lastBeat && !onceBit) |=> (busyQ && pingQ != $past(pingQ) && intStatQ));
  // R10: clearing enable stops at once
  p_stop_r10: assert property (@(posedge clk) disable iff (!rstN)
    stopNow |=> !busyQ);
  // R12: interrupt needs the status bit
  p_irq_source_r12: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> intStatQ);
endmodule

// File: rtl/dma_pingpong_datapath.sv
module dma_pingpong_datapath
  import dma_pingpong_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  walkCmd_t          cmd,
  input  logic [DATA_W-1:0] memBase,
  input  logic [DATA_W-1:0] perBase,
  input  logic [2:0]        memWrapCode,
  input  logic [2:0]        perWrapCode,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [DATA_W-1:0] perRdata,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] perAddr,
  output logic              memWe,
  output logic              memRe,
  output logic              perWe,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] perWdata
);
  logic [WIN_W-1:0] memWindow, perWindow;

  function automatic logic [WIN_W-1:0] memWin(input logic [2:0] code);
    return (code == 3'd0) ? '0 : (WIN_W'(16) << code);
  endfunction

  function automatic logic [WIN_W-1:0] perWin(input logic [2:0] code);
    return (code == 3'd0) ? '0 : (WIN_W'(1) << (code - 3'd1));
  endfunction

  assign memWindow = memWin(memWrapCode);
  assign perWindow = perWin(perWrapCode);

  dma_ptr_walker #(.PTR_W(DATA_W), .IDX_W(WIN_W)) memSide (
    .clk(clk), .rstN(rstN), .load(cmd.load), .step(cmd.step),
    .base(memBase), .window(memWindow), .ptr(memAddr));

  dma_ptr_walker #(.PTR_W(DATA_W), .IDX_W(WIN_W)) perSide (
    .clk(clk), .rstN(rstN), .load(cmd.load), .step(cmd.step),
    .base(perBase), .window(perWindow), .ptr(perAddr));

  assign memWe    = cmd.step && !cmd.toPer;
  assign memRe    = cmd.step && cmd.toPer;
  assign perWe    = cmd.step && cmd.toPer;
  assign memWdata = perRdata;
  assign perWdata = memRdata;

  // R4: exactly one side is written per beat
  p_one_writer_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmd.step |-> $onehot({memWe, perWe}));
endmodule

// File: rtl/dma_pingpong_chan.sv
module dma_pingpong_chan
  import dma_pingpong_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        perReq,
  output logic        perAck,
  output logic [31:0] perAddr,
  output logic        perWe,
  output logic [31:0] perWdata,
  input  logic [31:0] perRdata,
  output logic [31:0] memAddr,
  output logic        memWe,
  output logic        memRe,
  output logic [31:0] memWdata,
  input  logic [31:0] memRdata,
  output logic        irq
);
  walkCmd_t          cmd;
  logic [DATA_W-1:0] memBase, perBase;
  logic [2:0]        memWrapCode, perWrapCode;

  dma_pingpong_ctrl ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .perReq(perReq),
    .perAck(perAck), .irq(irq), .cmd(cmd), .memBase(memBase),
    .perBase(perBase), .memWrapCode(memWrapCode), .perWrapCode(perWrapCode));

  dma_pingpong_datapath dpath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .memBase(memBase), .perBase(perBase),
    .memWrapCode(memWrapCode), .perWrapCode(perWrapCode),
    .memRdata(memRdata), .perRdata(perRdata), .memAddr(memAddr),
    .perAddr(perAddr), .memWe(memWe), .memRe(memRe), .perWe(perWe),
    .memWdata(memWdata), .perWdata(perWdata));
endmodule

// File: tb/dma_pingpong_chan_test.sv
module dma_pingpong_chan_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        perReq = 1'b0;
  logic        perAck, perWe, memWe, memRe, irq;
  logic [31:0] perAddr, perWdata, memAddr, memWdata;
  logic [31:0] perRdata = '0;
  logic [31:0] memRdata = '0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dma_pingpong_chan uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdata;
  endtask

  function automatic logic [31:0] ctrlWord(input bit en, input bit ie, input bit hold,
      input bit dir, input bit once, input bit flow, input logic [4:0] sel,
      input logic [13:0] cnt);
    return {en, ie, hold, dir, once, 5'd0, flow, sel, cnt, 2'd0};
  endfunction

  function automatic logic [31:0] seqWord(input logic [2:0] code);
    return {1'b0, 3'd2, 1'b0, 3'd4, 4'd0, 1'b1, code, 16'd0};
  endfunction

  task automatic runOneShot(input bit dir, input int cnt, input logic [2:0] mCode,
      input logic [2:0] pCode, input bit flow);
    logic [31:0] s;
    int mWin, pWin;
    mWin = (mCode == 0) ? 0 : (16 << mCode);
    pWin = (pCode == 0) ? 0 : (1 << (pCode - 1));
    wr(3'd2, 32'h0001_0000);
    wr(3'd4, 32'h0000_0400);
    wr(3'd3, seqWord(mCode));
    wr(3'd5, seqWord(pCode));
    perReq = 1'b0;
    wr(3'd0, ctrlWord(1, 1, 0, dir, 1, flow, 5'd2, 14'(cnt)));
    for (int i = 0; i <= cnt; i++) begin
      perReq = flow;
      perRdata = 32'hA500_0000 + i;
      memRdata = 32'hB600_0000 + i;
      rd(3'd1, s);
      chk("R2 remaining count", {18'd0, s[15:2]}, cnt - i);
      chk("R5 memory pointer", memAddr, 32'h0001_0000 + 4 * ((mWin == 0) ? i : i % mWin));
      chk("R5 peripheral pointer", perAddr, 32'h0000_0400 + 4 * ((pWin == 0) ? i : i % pWin));
      chk("R3 ack", {31'd0, perAck}, {31'd0, flow});
      chk("R4 strobes", {29'd0, memWe, memRe, perWe}, dir ? 32'd3 : 32'd4);
      if (dir) chk("R4 data to peripheral", perWdata, 32'hB600_0000 + i);
      else     chk("R4 data to memory", memWdata, 32'hA500_0000 + i);
      @(negedge clk);
    end
    perReq = 1'b0;
    rd(3'd1, s);
    chk("R6 busy clear and status set", s[31:30], 32'd1);
    rd(3'd0, s);
    chk("R6 enable cleared", {31'd0, s[31]}, 32'd0);
    chk("R6 no beat after end", {29'd0, memWe, memRe, perWe}, 32'd0);
  endtask

  initial begin
    logic [31:0] s;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), s);
      chk("R1 register reset", s, 32'd0);
    end
    chk("R1 outputs idle", {28'd0, irq, perAck, memWe, perWe}, 32'd0);

    // R2 R3 R4 R5 R6 sweep
    runOneShot(0, 0, 3'd0, 3'd0, 1);
    wr(3'd1, 32'h4000_0000);
    runOneShot(1, 0, 3'd0, 3'd0, 1);
    wr(3'd1, 32'h4000_0000);
    runOneShot(0, 3, 3'd0, 3'd1, 1);
    wr(3'd1, 32'h4000_0000);
    runOneShot(1, 5, 3'd0, 3'd2, 0);
    wr(3'd1, 32'h4000_0000);
    runOneShot(0, 39, 3'd1, 3'd3, 1);
    wr(3'd1, 32'h4000_0000);
    runOneShot(1, 39, 3'd1, 3'd0, 0);

    // R12: status still set from the last block
    for (int k = 0; k < 8; k++) begin
      wr(3'd6, {k[2], 30'd0, k[1]});
      wr(3'd0, ctrlWord(0, k[0], 0, 0, 1, 1, 5'd0, 14'd0));
      #1 chk("R12 irq gating", {31'd0, irq}, {31'd0, k == 7});
    end
    // R11
    wr(3'd1, 32'hBFFF_FFFF);
    rd(3'd1, s);
    chk("R11 write without bit30 keeps status", {31'd0, s[30]}, 32'd1);
    wr(3'd1, 32'h4000_0000);
    rd(3'd1, s);
    chk("R11 write with bit30 clears status", {31'd0, s[30]}, 32'd0);
    chk("R12 irq falls with status", {31'd0, irq}, 32'd0);

    // R7 R8: continuous, 4 words per half
    wr(3'd2, 32'h0000_1000);
    wr(3'd4, 32'h0000_0200);
    wr(3'd3, seqWord(3'd0));
    wr(3'd5, seqWord(3'd0));
    wr(3'd0, ctrlWord(1, 1, 0, 0, 0, 1, 5'd4, 14'd3));
    for (int i = 0; i < 9; i++) begin
      if (i == 4) begin
        perReq = 1'b0;
        rd(3'd1, s);
        chk("R7 first half status", {28'd0, s[31], s[30], s[28], 1'b0}, 32'hE);
        chk("R7 count reloaded", {18'd0, s[15:2]}, 32'd3);
        wr(3'd2, 32'h0000_3000);
        wr(3'd1, 32'h4000_0000);
      end
      if (i == 8) begin
        perReq = 1'b0;
        rd(3'd1, s);
        chk("R7 second half ping back", {28'd0, s[31], s[30], s[28], 1'b0}, 32'hC);
      end
      perReq = 1'b1;
      #1;
      if (i < 8) chk("R7 R8 pointer continues across halves", memAddr, 32'h0000_1000 + 4 * i);
      else       chk("R8 shadow pointer used at buffer start", memAddr, 32'h0000_3000);
      if (i == 8) chk("R7 peripheral pointer restarts", perAddr, 32'h0000_0200);
      @(negedge clk);
    end
    perReq = 1'b0;

    // R9: blocked selector
    wr(3'd0, ctrlWord(1, 1, 0, 0, 0, 1, 5'd31, 14'd3));
    perReq = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #1 chk("R9 no ack when blocked", {30'd0, perAck, memWe}, 32'd0);
      @(negedge clk);
    end
    rd(3'd1, s);
    chk("R9 busy and count held", {s[31], 17'd0, s[15:2]}, {1'b1, 17'd0, 14'd2});
    perReq = 1'b0;
    wr(3'd0, ctrlWord(1, 1, 1, 0, 0, 1, 5'd4, 14'd3));
    perReq = 1'b1;
    #1 chk("R9 hold blocks beats", {31'd0, perAck}, 32'd0);
    perReq = 1'b0;
    wr(3'd0, ctrlWord(1, 1, 0, 0, 0, 1, 5'd4, 14'd3));
    perReq = 1'b1;
    #1 chk("R9 resumes at next address", memAddr, 32'h0000_3004);
    @(negedge clk);
    perReq = 1'b0;

    // R10
    wr(3'd0, ctrlWord(0, 1, 0, 0, 0, 1, 5'd4, 14'd3));
    rd(3'd1, s);
    chk("R10 busy clears", {31'd0, s[31]}, 32'd0);
    perReq = 1'b1;
    #1 chk("R10 no beat after stop", {30'd0, perAck, memWe}, 32'd0);
    @(negedge clk);
    perReq = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule